// File: doc/BRIEF.md
# SPI receive queue controller

This block sits between the receive side of an SPI shifter and whatever drains the received words, whether a host or a DMA engine. Each completed frame coming out of the shift logic is first caught in a one-word holding stage, which stands in for the shift register. On the following clock edge that word moves into a small circular queue, as long as the queue has a free slot. The reader takes words out in arrival order through a valid/ready port. The block also keeps two status flags: a sticky overflow flag, and a drain-request flag that asks the reader to come back.

The frame input carries a valid strobe and no ready. A serial link cannot be stalled, so back-pressure is handled by overflow rather than by holding off the sender. A frame that arrives while the holding stage is occupied and the queue is full is an overflow. The overwrite control input decides what happens to that frame: it either replaces the held word or is thrown away. On the read side, `rd_valid` is high whenever the queue holds at least one word, and a word is consumed on every cycle in which `rd_ready` is high. When `rd_valid` is low, `rd_ready` is ignored. `rd_data` always shows the oldest word, and its value is meaningless while `rd_valid` is low.

Status flags are cleared by writing ones through `st_clr_en` and `st_clr_bits`. Bit 0 of `st_clr_bits` targets the drain flag and bit 1 targets the overflow flag.

Top module: `spi_rxq_ctrl`

## Requirements
- R1: A synchronous active-high reset empties the queue, sets `rd_count` to 0, and clears `rd_valid`, `ovf_flag` and `drain_req` by the first clock edge after it.
- R2: A frame is caught in the holding stage at the edge where `frm_valid` is sampled. It moves into the queue on the next edge if `rd_count` is below 4. Each move raises `rd_count` by one, and `rd_count` never exceeds 4.
- R3: `rd_valid` equals (`rd_count` != 0). `rd_data` shows the oldest stored word. Each cycle with `rd_valid` and `rd_ready` both high removes that word and lowers `rd_count` by one, so words leave in arrival order.
- R4: `rd_ready` while the queue is empty has no effect. `rd_count` stays 0, and the next frame stored is the next word read.
- R5: In a cycle where a word moves in and a word is read out while `rd_count` is between 1 and 3, `rd_count` is unchanged.
- R6: A frame arriving while the holding stage is occupied and the queue holds 4 words sets `ovf_flag` on the next edge. The flag stays set until it is cleared.
- R7: On overflow with `ovf_keep_new` high, the new frame replaces the held word. With `ovf_keep_new` low, the new frame is discarded and the held word is kept.
- R8: `drain_req` is 1 in every cycle where `rd_count` != 0. Writing 1 to bit 0 while words remain does not clear it.
- R9: Once the queue is empty, `drain_req` clears on an edge where `dma_rd_done` is high or bit 0 is written with 1. Otherwise it holds its value.
- R10: Writing 1 to bit 1 clears `ovf_flag`. A new overflow in the same cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Completed frame from the shift logic |
| frm_data | input | 32 | Frame contents |
| ovf_keep_new | input | 1 | On overflow, 1 keeps the new frame and 0 drops it |
| rd_valid | output | 1 | Queue holds a word |
| rd_ready | input | 1 | Reader consumes the oldest word |
| rd_data | output | 32 | Oldest stored word |
| rd_count | output | 3 | Number of stored words |
| dma_rd_done | input | 1 | DMA read-complete strobe |
| st_clr_en | input | 1 | Status write-one-to-clear strobe |
| st_clr_bits | input | 2 | Bit 0 targets the drain flag, bit 1 the overflow flag |
| ovf_flag | output | 1 | Sticky overflow status |
| drain_req | output | 1 | Drain request |

## Verification
The bench fills the queue with back-to-back frames until a frame overflows, once with the overwrite input low and once with it high. A design that mixed up the two policies would return the wrong final word after the queue is drained. Reads on an empty queue are placed just before a new frame arrives: a read pointer that moves on an empty read would return a stale or skipped word, and a counter that moves would wrap to 7. Streaming with a read and a write in the same cycle catches a counter that changes by one when it should stay still. Clears are timed against new overflows and against a queue that still holds words, which catches a drain flag that drops too early and an overflow clear that wins over a new overflow.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;
  localparam int RXQ_DATA_W = 32;
  localparam int RXQ_DEPTH  = 4;
  localparam int ST_W       = 2;
  localparam int ST_DRAIN   = 0;
  localparam int ST_OVF     = 1;
endpackage

// File: rtl/spi_rxq_hold.sv
module spi_rxq_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              keep_new_i,
  input  logic              q_full_i,
  output logic              move_o,
  output logic [DATA_W-1:0] move_data_o,
  output logic              ovf_evt_o
);
  logic              held_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign move_o      = held_q && !q_full_i;
  assign move_data_o = data_q;
  assign take        = frm_valid_i && (!held_q || move_o);
  assign ovf_evt_o   = frm_valid_i && held_q && !move_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) held_q <= 1'b1;
      else if (move_o) held_q <= 1'b0;
      if (take || (ovf_evt_o && keep_new_i)) data_q <= frm_data_i;
    end
  end

  // R7
  drop_keeps_old_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt_o && !keep_new_i) |=> (held_q && data_q == $past(data_q)));
  // R7
  keep_new_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt_o && keep_new_i) |=> (held_q && data_q == $past(frm_data_i)));
endmodule

// File: rtl/spi_rxq_fifo.sv
module spi_rxq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_i,
  input  logic [DATA_W-1:0]         push_data_i,
  input  logic                      pop_i,
  output logic [DATA_W-1:0]         head_o,
  output logic [$clog2(DEPTH):0]    cnt_o,
  output logic                      full_o,
  output logic                      nonempty_next_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == FULL_CNT);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign head_o  = slot_q[rd_q];
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end
  assign nonempty_next_o = (cnt_d != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= '0;
      else if (push_ok && wr_q == PTR_W'(i)) slot_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      cnt_q <= cnt_d;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL_CNT);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && cnt_q == '0 && !push_i) |=> (cnt_q == '0 && rd_q == $past(rd_q)));
  // R5
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && cnt_q != '0 && !full_o) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/spi_rxq_flags.sv
module spi_rxq_flags #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ovf_evt_i,
  input  logic            nonempty_next_i,
  input  logic            dma_done_i,
  input  logic            clr_en_i,
  input  logic [ST_W-1:0] clr_bits_i,
  output logic            ovf_o,
  output logic            drain_o
);
  import spi_rxq_pkg::*;
  logic ovf_q, drain_q, clr_ovf, clr_drain;

  assign clr_ovf   = clr_en_i && clr_bits_i[ST_OVF];
  assign clr_drain = clr_en_i && clr_bits_i[ST_DRAIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q   <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      if (ovf_evt_i) ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      if (nonempty_next_i) drain_q <= 1'b1;
      else if (dma_done_i || clr_drain) drain_q <= 1'b0;
    end
  end
  assign ovf_o   = ovf_q;
  assign drain_o = drain_q;

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);
  // R10
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt_i |=> ovf_q);
endmodule

// File: rtl/spi_rxq_ctrl.sv
module spi_rxq_ctrl #(
  parameter int DATA_W = spi_rxq_pkg::RXQ_DATA_W,
  parameter int DEPTH  = spi_rxq_pkg::RXQ_DEPTH,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int ST_W  = spi_rxq_pkg::ST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              ovf_keep_new,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_count,
  input  logic              dma_rd_done,
  input  logic              st_clr_en,
  input  logic [ST_W-1:0]   st_clr_bits,
  output logic              ovf_flag,
  output logic              drain_req
);
  logic              q_full, move, ovf_evt, nonempty_next;
  logic [DATA_W-1:0] move_data;

  spi_rxq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .frm_valid_i(frm_valid), .frm_data_i(frm_data),
    .keep_new_i(ovf_keep_new), .q_full_i(q_full), .move_o(move),
    .move_data_o(move_data), .ovf_evt_o(ovf_evt)
  );

  spi_rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(move), .push_data_i(move_data),
    .pop_i(rd_ready), .head_o(rd_data), .cnt_o(rd_count),
    .full_o(q_full), .nonempty_next_o(nonempty_next)
  );

  spi_rxq_flags #(.ST_W(ST_W)) u_flags (
    .clk(clk), .rst(rst), .ovf_evt_i(ovf_evt), .nonempty_next_i(nonempty_next),
    .dma_done_i(dma_rd_done), .clr_en_i(st_clr_en), .clr_bits_i(st_clr_bits),
    .ovf_o(ovf_flag), .drain_o(drain_req)
  );

  assign rd_valid = (rd_count != '0);

  // R8
  drain_level_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_count != '0) |-> drain_req);
  // R6
  ovf_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag)) |-> $past(q_full));
endmodule

// File: tb/spi_rxq_ctrl_tb.sv
module spi_rxq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0, ovf_keep_new = 1'b0, rd_ready = 1'b0;
  logic        dma_rd_done = 1'b0, st_clr_en = 1'b0;
  logic [1:0]  st_clr_bits = '0;
  logic [31:0] frm_data = '0;
  logic        rd_valid, ovf_flag, drain_req;
  logic [31:0] rd_data;
  logic [2:0]  rd_count;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference
  logic [31:0] mq[$];
  bit          m_held = 0, m_ovf = 0, m_drain = 0;
  logic [31:0] m_hdata = '0;

  spi_rxq_ctrl u_dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .ovf_keep_new(ovf_keep_new), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_count(rd_count), .dma_rd_done(dma_rd_done),
    .st_clr_en(st_clr_en), .st_clr_bits(st_clr_bits),
    .ovf_flag(ovf_flag), .drain_req(drain_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_held = 0; m_ovf = 0; m_drain = 0;
    end else begin
      bit mv, pp, ov;
      mv = m_held && mq.size() < 4;
      pp = rd_ready && mq.size() > 0;
      ov = frm_valid && m_held && !mv;
      if (pp) void'(mq.pop_front());
      if (mv) mq.push_back(m_hdata);
      if (frm_valid && !ov) begin m_held = 1; m_hdata = frm_data; end
      else if (ov) begin if (ovf_keep_new) m_hdata = frm_data; end
      else if (mv) m_held = 0;
      if (ov) m_ovf = 1;
      else if (st_clr_en && st_clr_bits[1]) m_ovf = 0;
      if (mq.size() != 0) m_drain = 1;
      else if (dma_rd_done || (st_clr_en && st_clr_bits[0])) m_drain = 0;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      chk(rd_count == 3'(mq.size()), "R2/R5 count", 32'(rd_count), 32'(mq.size()));
      chk(rd_valid == (mq.size() != 0), "R3 valid", 32'(rd_valid), 32'(mq.size() != 0));
      if (mq.size() != 0) chk(rd_data == mq[0], "R3/R7 data", rd_data, mq[0]);
      chk(ovf_flag == m_ovf, "R6/R10 overflow", 32'(ovf_flag), 32'(m_ovf));
      chk(drain_req == m_drain, "R8/R9 drain", 32'(drain_req), 32'(m_drain));
    end
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic idle();
    frm_valid = 0; rd_ready = 0; dma_rd_done = 0; st_clr_en = 0; st_clr_bits = 0;
  endtask
  task automatic send(input logic [31:0] d);
    tick(); idle(); frm_valid = 1; frm_data = d;
  endtask
  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin tick(); idle(); rd_ready = 1; end
  endtask
  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) begin tick(); idle(); end
  endtask

  initial begin
    wait_n(3);
    tick(); rst = 0;
    tick();
    // R1
    chk(rd_count == 0 && !rd_valid && !ovf_flag && !drain_req, "R1 reset",
        {rd_count, rd_valid, ovf_flag, drain_req}, 0);
    cmp_on = 1;
    send(32'hA0);
    wait_n(2);
    // R2: frame present two edges after capture
    chk(rd_count == 1 && rd_data == 32'hA0, "R2 single frame", rd_data, 32'hA0);
    pop_n(1); wait_n(1);
    // R4: empty read then a frame
    pop_n(3);
    chk(rd_count == 0, "R4 empty pop count", 32'(rd_count), 0);
    send(32'hB1); wait_n(2);
    chk(rd_data == 32'hB1, "R4 pointer unchanged", rd_data, 32'hB1);
    // R9: drain stays until DMA done once empty
    pop_n(1); wait_n(2);
    chk(drain_req == 1, "R9 drain held when empty", 32'(drain_req), 1);
    tick(); idle(); dma_rd_done = 1; wait_n(1);
    chk(drain_req == 0, "R9 drain cleared by DMA", 32'(drain_req), 0);
    // R6/R7 overflow with drop
    ovf_keep_new = 0;
    for (int i = 1; i <= 6; i++) send(32'h100 + i);
    wait_n(2);
    chk(ovf_flag == 1 && rd_count == 4, "R6 overflow set", 32'(ovf_flag), 1);
    // R8: clear drain while non-empty has no effect
    tick(); idle(); st_clr_en = 1; st_clr_bits = 2'b01; wait_n(1);
    chk(drain_req == 1, "R8 drain kept", 32'(drain_req), 1);
    // R7 keep-new
    ovf_keep_new = 1; send(32'h1FF); wait_n(1);
    // R10 clear while overflow repeats: set wins
    send(32'h2EE); st_clr_en = 1; st_clr_bits = 2'b10; wait_n(1);
    chk(ovf_flag == 1, "R10 set wins", 32'(ovf_flag), 1);
    pop_n(5); wait_n(2);
    chk(rd_count == 0, "R7 drained", 32'(rd_count), 0);
    tick(); idle(); st_clr_en = 1; st_clr_bits = 2'b11; wait_n(1);
    chk(!ovf_flag && !drain_req, "R10 clear both", {ovf_flag, drain_req}, 0);
    // R5: streaming push and pop together
    send(32'h300); send(32'h301);
    for (int i = 0; i < 10; i++) begin
      tick(); idle(); frm_valid = 1; frm_data = 32'h310 + i; rd_ready = 1;
    end
    pop_n(4); wait_n(3);
    chk(rd_count == 0, "R5 stream drained", 32'(rd_count), 0);
    // reset mid-fill
    send(32'h400); send(32'h401); wait_n(2);
    tick(); rst = 1; tick(); rst = 0;
    chk(rd_count == 0 && !drain_req, "R1 reset mid-fill", 32'(rd_count), 0);
    wait_n(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule